// File: doc/BRIEF.md
# Tearing-Effect Paced Frame Scheduler

This block decides when a frame is sent to a command-mode display panel. A frame can be launched in two ways: by a one-cycle software start pulse, or by automatic refresh, which counts rising edges of the panel's tearing-effect (TE) signal and launches a frame once a programmed number of them has been seen. Each frame is modelled as a busy window of `FRAME_CYCLES` clock cycles. A single-cycle completion interrupt marks the end of the window.

The refresh settings are held in two copies. Software writes a pending copy through a small register port and then requests a flush. The pending value moves into the active copy only when a frame is launched. Because of this, turning on automatic refresh from a cold state takes one explicit start. Reads always return the pending copy. The active copy cannot be read.

The launch logic is a two-state machine. In `S_IDLE` it waits. The transition `IDLE->BUSY` (the "trigger") is taken on a start pulse, or on the TE edge that completes the programmed count while refresh is active. In `S_BUSY` a cycle counter runs. The transition `BUSY->IDLE` is taken when that counter reaches `FRAME_CYCLES-1`. The interrupt is raised on that transition.

Top module: `frame_sched_top`

## Requirements
- R1: A write to address 0 stores the pending configuration: bit 31 is the refresh enable and bits 15:0 are the TE count. Bits 30:16 read as zero. A read of address 0 returns the pending value.
- R2: Writing address 1 with bit 0 set requests a flush. Reading address 1 returns the flush-pending flag in bit 0. The flag clears when the pending copy is transferred into the active copy.
- R3: The transfer happens only at a trigger. Without a start and without active refresh, a requested flush stays pending indefinitely, and TE edges launch no frame.
- R4: A start pulse seen in `S_IDLE` launches exactly one frame. `frame_busy` is high from the next cycle for exactly `FRAME_CYCLES` cycles.
- R5: `done_irq` is high for exactly one cycle, the cycle in which `frame_busy` falls, once per frame.
- R6: When the active enable is set with count N, a frame is launched on the Nth TE rising edge counted since the last trigger. A count of 0 acts as 1. The TE counter clears on every trigger and while the active enable is clear.
- R7: A start pulse or TE edge that arrives while `frame_busy` is high is ignored. It neither launches an extra frame nor advances the TE count.
- R8: TE passes through a two-flop synchronizer and only its rising edge is used. With refresh active and count 1, `frame_busy` rises at the third clock edge that samples `te_in` high.
- R9: Synchronous active-high reset clears both configuration copies, the flush flag, the TE counter, `frame_busy` and `done_irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register address: 0 = configuration, 1 = control/status |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| te_in | input | 1 | Tearing-effect signal from the panel (asynchronous) |
| start_in | input | 1 | Software start pulse |
| frame_busy | output | 1 | High while a frame is being sent |
| done_irq | output | 1 | One-cycle frame completion pulse |

## Verification
If the active copy is taken at the wrong moment, the fault first shows up as the wrong number of `done_irq` pulses for a given number of TE edges. It is visible within one frame window after the next trigger. A stuck or wrongly cleared flush flag appears on a read of address 1 right after the action that should have set or cleared it. A TE counter that is not cleared, or that counts during a busy window, shifts the frame launch by one TE edge. A fault in the busy counter, or a retrigger, changes the measured `frame_busy` width or the count of interrupt cycles.

// File: rtl/fs_pkg.sv
package fs_pkg;
    localparam int DATA_W   = 32;
    localparam int CNT_W    = 16;
    localparam int EN_BIT   = 31;
    localparam int FLUSH_BIT = 0;
    localparam logic ADDR_CFG = 1'b0;
    localparam logic ADDR_CTL = 1'b1;
    localparam logic [DATA_W-1:0] CFG_MASK =
        (DATA_W'(1) << EN_BIT) | ((DATA_W'(1) << CNT_W) - DATA_W'(1));

    typedef enum logic {
        S_IDLE = 1'b0,
        S_BUSY = 1'b1
    } fs_state_e;

    typedef struct packed {
        logic             en;
        logic [CNT_W-1:0] cnt;
    } fs_cfg_t;
endpackage

// File: rtl/fs_te_sync.sv
module fs_te_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic te_async,
    output logic te_rise
);
    logic [STAGES-1:0] sync_q;
    logic              prev_q;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) sync_q[0] <= 1'b0;
                    else     sync_q[0] <= te_async;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) sync_q[i] <= 1'b0;
                    else     sync_q[i] <= sync_q[i-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= sync_q[STAGES-1];
    end

    assign te_rise = sync_q[STAGES-1] & ~prev_q;

    // R8: an edge is reported for a single cycle only
    a_r8_single_rise: assert property (@(posedge clk) disable iff (rst)
        te_rise |=> !te_rise);
endmodule

// File: rtl/fs_cfg_regs.sv
module fs_cfg_regs
    import fs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic              addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              trigger,
    output logic [DATA_W-1:0] rdata,
    output fs_cfg_t           act_cfg,
    output logic              flush_pend
);
    logic [DATA_W-1:0] pend_q;
    fs_cfg_t           act_q;
    logic              flush_q;
    logic              flush_wr;

    assign flush_wr = we && (addr == ADDR_CTL) && wdata[FLUSH_BIT];

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= '0;
        end else if (we && addr == ADDR_CFG) begin
            pend_q <= wdata & CFG_MASK;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q   <= '0;
            flush_q <= 1'b0;
        end else begin
            if (trigger && flush_q) begin
                act_q.en  <= pend_q[EN_BIT];
                act_q.cnt <= pend_q[CNT_W-1:0];
            end
            if (flush_wr)                flush_q <= 1'b1;
            else if (trigger && flush_q) flush_q <= 1'b0;
        end
    end

    always_comb begin
        unique case (addr)
            ADDR_CFG: rdata = pend_q;
            ADDR_CTL: rdata = DATA_W'(flush_q) << FLUSH_BIT;
            default:  rdata = '0;
        endcase
    end

    assign act_cfg    = act_q;
    assign flush_pend = flush_q;

    // R3: the active copy changes only at a trigger
    a_r3_active_hold: assert property (@(posedge clk) disable iff (rst)
        !trigger |=> $stable(act_q));
    // R2: a pending flush is consumed by the trigger
    a_r2_flush_consumed: assert property (@(posedge clk) disable iff (rst)
        (trigger && flush_q && !flush_wr) |=> !flush_q);
    // R2: without a trigger the flag cannot drop
    a_r2_flush_sticky: assert property (@(posedge clk) disable iff (rst)
        (flush_q && !trigger) |=> flush_q);
endmodule

// File: rtl/fs_frame_fsm.sv
module fs_frame_fsm
    import fs_pkg::*;
#(
    parameter int FRAME_CYCLES = 16
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    start,
    input  logic    te_rise,
    input  fs_cfg_t act_cfg,
    output logic    trigger,
    output logic    busy,
    output logic    done
);
    localparam int BC_W = (FRAME_CYCLES > 1) ? $clog2(FRAME_CYCLES) : 1;
    localparam logic [BC_W-1:0] BC_LAST = BC_W'(FRAME_CYCLES - 1);

    fs_state_e        state_q, state_d;
    logic [BC_W-1:0]  bcnt_q;
    logic [CNT_W-1:0] te_cnt_q;
    logic [CNT_W-1:0] eff_cnt;
    logic             te_hit;
    logic             frame_end;
    logic             done_q;

    assign eff_cnt   = (act_cfg.cnt == '0) ? CNT_W'(1) : act_cfg.cnt;
    assign te_hit    = act_cfg.en && te_rise &&
                       ({1'b0, te_cnt_q} + (CNT_W+1)'(1) >= {1'b0, eff_cnt});
    assign frame_end = (state_q == S_BUSY) && (bcnt_q == BC_LAST);

    // next-state logic: IDLE->BUSY on trigger, BUSY->IDLE at end of window
    always_comb begin
        state_d = state_q;
        trigger = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                if (start || te_hit) begin
                    trigger = 1'b1;
                    state_d = S_BUSY;
                end
            end
            S_BUSY: begin
                if (bcnt_q == BC_LAST) state_d = S_IDLE;
            end
            default: state_d = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= S_IDLE;
        else     state_q <= state_d;
    end

    // busy window counter
    always_ff @(posedge clk) begin
        if (rst || state_q == S_IDLE) bcnt_q <= '0;
        else if (!frame_end)          bcnt_q <= bcnt_q + BC_W'(1);
    end

    // TE counter: counts only while idle and enabled
    always_ff @(posedge clk) begin
        if (rst || trigger || !act_cfg.en)          te_cnt_q <= '0;
        else if (state_q == S_IDLE && te_rise)       te_cnt_q <= te_cnt_q + CNT_W'(1);
    end

    // outputs
    always_ff @(posedge clk) begin
        if (rst) done_q <= 1'b0;
        else     done_q <= frame_end;
    end

    assign busy = (state_q == S_BUSY);
    assign done = done_q;

    // R5: completion pulse coincides with busy falling
    a_r5_done_on_fall: assert property (@(posedge clk) disable iff (rst)
        done |-> ($past(busy) && !busy));
    // R5: pulse lasts one cycle
    a_r5_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    // R4: a trigger always opens a busy window
    a_r4_trigger_busy: assert property (@(posedge clk) disable iff (rst)
        trigger |=> busy);
    // R7: no trigger while a frame is in flight
    a_r7_no_retrigger: assert property (@(posedge clk) disable iff (rst)
        busy |-> !trigger);
endmodule

// File: rtl/frame_sched_top.sv
module frame_sched_top
    import fs_pkg::*;
#(
    parameter int FRAME_CYCLES = 16,
    parameter int SYNC_STAGES  = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_we,
    input  logic        reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic        te_in,
    input  logic        start_in,
    output logic        frame_busy,
    output logic        done_irq
);
    logic    te_rise;
    logic    trigger;
    logic    flush_pend;
    fs_cfg_t act_cfg;

    fs_te_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .te_async (te_in),
        .te_rise  (te_rise)
    );

    fs_cfg_regs u_cfg (
        .clk        (clk),
        .rst        (rst),
        .we         (reg_we),
        .addr       (reg_addr),
        .wdata      (reg_wdata),
        .trigger    (trigger),
        .rdata      (reg_rdata),
        .act_cfg    (act_cfg),
        .flush_pend (flush_pend)
    );

    fs_frame_fsm #(.FRAME_CYCLES(FRAME_CYCLES)) u_fsm (
        .clk     (clk),
        .rst     (rst),
        .start   (start_in),
        .te_rise (te_rise),
        .act_cfg (act_cfg),
        .trigger (trigger),
        .busy    (frame_busy),
        .done    (done_irq)
    );

    // R3: with refresh inactive, only a start can open a frame
    a_r3_no_te_frame_cold: assert property (@(posedge clk) disable iff (rst)
        (!act_cfg.en && !start_in && !frame_busy) |=> !frame_busy);
    // R2: a trigger with a flush pending makes the flag visible as clear
    a_r2_flag_port: assert property (@(posedge clk) disable iff (rst)
        (trigger && flush_pend && !reg_we) |=> !flush_pend);
endmodule

// File: tb/tb_frame_sched_top.sv
`timescale 1ns/100ps
module tb_frame_sched_top;
    localparam int FC = 8;
    localparam int SETTLE = FC + 8;
    localparam logic [1:0] K_WR = 2'd0, K_FL = 2'd1, K_ST = 2'd2, K_TE = 2'd3;

    typedef struct packed {
        logic [1:0]  kind;
        logic [31:0] data;
        logic        rda;
        logic [3:0]  frames;
        logic [31:0] rd_exp;
    } vec_t;

    localparam int NV = 25;
    localparam vec_t VEC [NV] = '{
        '{K_WR, 32'h8000_0001, 1'b0, 4'd0, 32'h8000_0001}, // R1
        '{K_TE, 32'h0,         1'b1, 4'd0, 32'h0},         // R3 cold TE
        '{K_FL, 32'h1,         1'b1, 4'd0, 32'h1},         // R2
        '{K_TE, 32'h0,         1'b1, 4'd0, 32'h1},         // R3 stays pending
        '{K_ST, 32'h0,         1'b1, 4'd1, 32'h0},         // R4 R2
        '{K_TE, 32'h0,         1'b0, 4'd1, 32'h8000_0001}, // R6
        '{K_TE, 32'h0,         1'b1, 4'd1, 32'h0},         // R6
        '{K_WR, 32'hFFFF_0003, 1'b0, 4'd0, 32'h8000_0003}, // R1 mask
        '{K_FL, 32'h1,         1'b1, 4'd0, 32'h1},
        '{K_TE, 32'h0,         1'b1, 4'd1, 32'h0},         // R3 copy on TE frame
        '{K_TE, 32'h0,         1'b1, 4'd0, 32'h0},         // R6 count 3
        '{K_TE, 32'h0,         1'b1, 4'd0, 32'h0},
        '{K_TE, 32'h0,         1'b1, 4'd1, 32'h0},
        '{K_WR, 32'h0000_0000, 1'b0, 4'd0, 32'h0},
        '{K_FL, 32'h1,         1'b1, 4'd0, 32'h1},
        '{K_TE, 32'h0,         1'b1, 4'd0, 32'h1},
        '{K_TE, 32'h0,         1'b1, 4'd0, 32'h1},
        '{K_TE, 32'h0,         1'b1, 4'd1, 32'h0},         // R3 disable copied
        '{K_TE, 32'h0,         1'b1, 4'd0, 32'h0},         // R6 disabled
        '{K_WR, 32'h8000_0000, 1'b0, 4'd0, 32'h8000_0000},
        '{K_FL, 32'h1,         1'b1, 4'd0, 32'h1},
        '{K_TE, 32'h0,         1'b1, 4'd0, 32'h1},
        '{K_ST, 32'h0,         1'b1, 4'd1, 32'h0},
        '{K_TE, 32'h0,         1'b1, 4'd1, 32'h0},         // R6 count 0 as 1
        '{K_TE, 32'h0,         1'b1, 4'd1, 32'h0}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic        reg_addr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        te_in = 1'b0;
    logic        start_in = 1'b0;
    logic        frame_busy;
    logic        done_irq;

    int n_chk = 0;
    int n_fail = 0;
    int n_done = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    frame_sched_top #(.FRAME_CYCLES(FC)) dut (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .te_in(te_in),
        .start_in(start_in), .frame_busy(frame_busy), .done_irq(done_irq)
    );

    always @(negedge clk) if (done_irq) n_done++;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    task automatic wr(input logic a, input logic [31:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd_chk(input string req, input logic a, input logic [31:0] exp);
        reg_addr = a;
        #0.5;
        chk(req, reg_rdata, exp);
    endtask

    task automatic pulse_start();
        start_in = 1'b1;
        @(negedge clk);
        start_in = 1'b0;
    endtask

    task automatic pulse_te();
        te_in = 1'b1;
        repeat (3) @(negedge clk);
        te_in = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #(5.0 * 150000);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        summary();
    end

    initial begin
        int base;
        int blen;
        idle(3);
        // R9: reset state
        chk("R9 busy", {31'b0, frame_busy}, 32'h0);
        chk("R9 done", {31'b0, done_irq}, 32'h0);
        rd_chk("R9 cfg", 1'b0, 32'h0);
        rst = 1'b0;
        idle(2);

        for (int i = 0; i < NV; i++) begin
            base = n_done;
            unique case (VEC[i].kind)
                K_WR: wr(1'b0, VEC[i].data);
                K_FL: wr(1'b1, VEC[i].data);
                K_ST: pulse_start();
                default: pulse_te();
            endcase
            idle(SETTLE);
            chk($sformatf("R3/R6 vec%0d frames", i), n_done - base, 32'(VEC[i].frames));
            rd_chk($sformatf("R1/R2 vec%0d read", i), VEC[i].rda, VEC[i].rd_exp);
        end

        // R8: latency from TE to busy (active count is 0 -> treated as 1)
        te_in = 1'b1;
        @(negedge clk); chk("R8 lat1", {31'b0, frame_busy}, 32'h0);
        @(negedge clk); chk("R8 lat2", {31'b0, frame_busy}, 32'h0);
        @(negedge clk); chk("R8 lat3", {31'b0, frame_busy}, 32'h1);
        te_in = 1'b0;
        idle(SETTLE);

        // R4 R5 R7: start while busy is ignored, window length exact
        base = n_done;
        start_in = 1'b1;
        @(negedge clk);
        start_in = 1'b0;
        blen = 0;
        for (int c = 0; c < 3 * FC; c++) begin
            if (frame_busy) blen++;
            if (c == 3) start_in = 1'b1;
            if (c == 4) start_in = 1'b0;
            @(negedge clk);
        end
        chk("R4 busy width", blen, FC);
        chk("R7 start in busy ignored / R5 single done", n_done - base, 32'd1);

        // R7: TE during busy is not counted (count 2)
        wr(1'b0, 32'h8000_0002);
        wr(1'b1, 32'h1);
        pulse_start();
        idle(SETTLE);
        base = n_done;
        pulse_start();
        idle(1);
        te_in = 1'b1; idle(2); te_in = 1'b0;
        idle(SETTLE);
        chk("R7 frame from start", n_done - base, 32'd1);
        base = n_done;
        pulse_te(); idle(SETTLE);
        chk("R7 busy TE not counted", n_done - base, 32'd0);
        pulse_te(); idle(SETTLE);
        chk("R6 second TE fires", n_done - base, 32'd1);

        // R9: reset mid-operation clears everything
        wr(1'b1, 32'h1);
        rst = 1'b1; idle(2); rst = 1'b0;
        rd_chk("R9 cfg cleared", 1'b0, 32'h0);
        rd_chk("R9 flush cleared", 1'b1, 32'h0);
        base = n_done;
        pulse_te(); idle(SETTLE);
        chk("R9 active cleared", n_done - base, 32'd0);
        chk("R9 busy low", {31'b0, frame_busy}, 32'h0);

        summary();
    end
endmodule